// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This unit holds the instruction fetch address of a small 8-bit controller and moves it forward once per instruction cycle. A decoder outside the unit supplies an operation code for each cycle. Seven behaviours are possible: step to the next word, jump to an immediate target, call a subroutine, return, load the low byte from the accumulator, add the accumulator to the low byte, or do a table-lookup add that leaves the mid bits alone. The fetch address is 14 bits wide and so covers 16K words of program memory.

The four upper address bits are not part of the immediate field. They come from a page-select field that the status register feeds in, and they are loaded on every operation that writes a new target. Return addresses go onto an 8-entry circular stack. When the stack is full, a call overwrites the oldest entry. When it is empty, a return reads whatever stale entry the pointer lands on. The unit advances only in cycles where the cycle-enable input is high.

Top module: `paged_pc_unit`

## Requirements
- R1: After reset the fetch address is 0x0000 and the return stack is empty (its pointer is at slot 0).
- R2: Operation codes are 0 = step, 1 = jump, 2 = call, 3 = return, 4 = load from accumulator, 5 = accumulator add, 6 = table add. Code 7 acts as step. A step adds one to the address, and 0x3FFF wraps to 0x0000.
- R3: A jump places the 10-bit immediate in address bits 9..0.
- R4: A call places the immediate in bits 9..0 and pushes the old address plus one (14 bits, wrapping). A return loads all 14 bits from the newest stack entry and pops it.
- R5: A load from the accumulator puts the 8-bit accumulator in bits 7..0 and clears bits 9..8.
- R6: An accumulator add puts the 8-bit sum of bits 7..0 and the accumulator in bits 7..0, drops the carry and clears bits 9..8.
- R7: A table add forms the same 8-bit sum in bits 7..0 and leaves bits 9..8 as they were.
- R8: Jump, call, load, accumulator add and table add all copy the page-select input into bits 13..10.
- R9: The stack holds 8 entries and is circular. The ninth push overwrites the oldest entry, and a pop past empty returns the stale slot without any error.
- R10: While the cycle enable is low, neither the address nor the stack changes, whatever the operation code is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| cyc_en | input | 1 | Instruction-cycle enable |
| op | input | 3 | Operation code, per R2 |
| imm | input | 10 | Immediate target field |
| acc | input | 8 | Accumulator value |
| page | input | 4 | Page-select bits from the status register |
| pc | output | 14 | Current fetch address |

## Verification
A corrupted address shows at `pc` in the very next enabled cycle, so each vector checks the port one clock after it is applied. A fault in the stack pointer or in a stored slot stays hidden until a return reads that slot. For that reason the directed tests push past the full depth and then pop past empty, which exposes every slot and both pointer wraps within about twenty cycles. A missed hold while the enable is low shows up only at the next return, so a call issued while disabled is always followed by a return.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_LDA  = 3'd4,
    OP_ADDA = 3'd5,
    OP_TADD = 3'd6,
    OP_RSVD = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pcu_stack.sv
module pcu_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] sp_q, sp_d, sp_prev;
  logic [W-1:0]  slot [DEPTH];

  // sp_q always points at the next free slot
  always_comb begin
    sp_prev = (sp_q == '0) ? LAST : sp_q - 1'b1;
    sp_d    = sp_q;
    if (push)     sp_d = (sp_q == LAST) ? '0 : sp_q + 1'b1;
    else if (pop) sp_d = sp_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && sp_q == PW'(i)) slot[i] <= din;
    end
  end

  assign top = slot[sp_prev];

  assert_ptr_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == (($past(sp_q) == LAST) ? '0 : $past(sp_q) + 1'b1));
  assert_ptr_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp_q == (($past(sp_q) == '0) ? LAST : $past(sp_q) - 1'b1));
  assert_ptr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !push) |=> $stable(sp_q));
endmodule

// File: rtl/pcu_next.sv
module pcu_next
  import pcu_pkg::*;
#(
  parameter int PCW  = 14,
  parameter int IMMW = 10,
  parameter int ACCW = 8,
  parameter int PGW  = 4
) (
  input  logic [2:0]      op,
  input  logic [PCW-1:0]  pc_q,
  input  logic [IMMW-1:0] imm,
  input  logic [ACCW-1:0] acc,
  input  logic [PGW-1:0]  page,
  input  logic [PCW-1:0]  stack_top,
  output logic [PCW-1:0]  pc_d,
  output logic            push,
  output logic            pop
);
  localparam int MIDW = IMMW - ACCW;

  logic [PCW-1:0]  pc_inc;
  logic [ACCW-1:0] low_sum;
  pc_op_e          op_e;

  assign op_e    = pc_op_e'(op);
  assign pc_inc  = pc_q + 1'b1;
  assign low_sum = pc_q[ACCW-1:0] + acc;

  always_comb begin
    pc_d = pc_inc;
    push = 1'b0;
    pop  = 1'b0;
    unique case (op_e)
      OP_JMP:  pc_d = {page, imm};
      OP_CALL: begin
        pc_d = {page, imm};
        push = 1'b1;
      end
      OP_RET: begin
        pc_d = stack_top;
        pop  = 1'b1;
      end
      OP_LDA:  pc_d = {page, {MIDW{1'b0}}, acc};
      OP_ADDA: pc_d = {page, {MIDW{1'b0}}, low_sum};
      OP_TADD: pc_d = {page, pc_q[IMMW-1:ACCW], low_sum};
      OP_STEP, OP_RSVD: pc_d = pc_inc;
      default: pc_d = pc_inc;
    endcase
  end
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
  import pcu_pkg::*;
#(
  parameter int PCW   = 14,
  parameter int IMMW  = 10,
  parameter int ACCW  = 8,
  parameter int PGW   = 4,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_en,
  input  logic [2:0]      op,
  input  logic [IMMW-1:0] imm,
  input  logic [ACCW-1:0] acc,
  input  logic [PGW-1:0]  page,
  output logic [PCW-1:0]  pc
);
  localparam int MIDW = IMMW - ACCW;

  logic [1:0]     rst_sync;
  logic           rst_q_n;
  logic [PCW-1:0] pc_q, pc_d, stack_top;
  logic           push_raw, pop_raw, push, pop;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  pcu_next #(.PCW(PCW), .IMMW(IMMW), .ACCW(ACCW), .PGW(PGW)) u_next (
    .op(op), .pc_q(pc_q), .imm(imm), .acc(acc), .page(page),
    .stack_top(stack_top), .pc_d(pc_d), .push(push_raw), .pop(pop_raw)
  );

  assign push = cyc_en & push_raw;
  assign pop  = cyc_en & pop_raw;

  pcu_stack #(.DEPTH(DEPTH), .W(PCW)) u_stack (
    .clk(clk), .rst_n(rst_q_n), .push(push), .pop(pop),
    .din(pc_q + 1'b1), .top(stack_top)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    pc_q <= '0;
    else if (cyc_en) pc_q <= pc_d;
  end

  assign pc = pc_q;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cyc_en |=> $stable(pc));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc_en && (op == OP_STEP || op == OP_RSVD)) |=> pc == $past(pc) + 1'b1);
  assert_page_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc_en && op != OP_STEP && op != OP_RSVD && op != OP_RET)
      |=> pc[PCW-1:IMMW] == $past(page));
  assert_midclr_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc_en && (op == OP_LDA || op == OP_ADDA)) |=> pc[IMMW-1:ACCW] == '0);
  assert_midkeep_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc_en && op == OP_TADD) |=> pc[IMMW-1:ACCW] == $past(pc[IMMW-1:ACCW]));
  assert_lowsum_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc_en && (op == OP_ADDA || op == OP_TADD))
      |=> pc[ACCW-1:0] == ACCW'($past(pc[ACCW-1:0]) + $past(acc)));
  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc_en && (op == OP_JMP || op == OP_CALL)) |=> pc[IMMW-1:0] == $past(imm));
  assert_ret_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc_en && op == OP_RET) |=> pc == $past(stack_top));
endmodule

// File: tb/paged_pc_unit_test.sv
module paged_pc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_en;
  logic [2:0]  op;
  logic [9:0]  imm;
  logic [7:0]  acc;
  logic [3:0]  page;
  logic [13:0] pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  paged_pc_unit uut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .op(op),
    .imm(imm), .acc(acc), .page(page), .pc(pc)
  );

  // {en, op, imm, acc, page, expected pc}
  localparam int NV = 12;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 3'd0, 10'h000, 8'h00, 4'h0, 14'h0001},  // R2 step
    {1'b1, 3'd0, 10'h000, 8'h00, 4'h0, 14'h0002},  // R2 step
    {1'b1, 3'd1, 10'h3FF, 8'h00, 4'h5, 14'h17FF},  // R3 R8 jump
    {1'b1, 3'd2, 10'h310, 8'h00, 4'h2, 14'h0B10},  // R4 call, pushes 0x1800
    {1'b1, 3'd6, 10'h000, 8'hF5, 4'h3, 14'h0F05},  // R7 table add keeps 9..8
    {1'b1, 3'd5, 10'h000, 8'h01, 4'h3, 14'h0C06},  // R6 acc add clears 9..8
    {1'b1, 3'd3, 10'h000, 8'h00, 4'h9, 14'h1800},  // R4 return
    {1'b1, 3'd4, 10'h000, 8'hAB, 4'hF, 14'h3CAB},  // R5 load acc
    {1'b1, 3'd1, 10'h3FF, 8'h00, 4'hF, 14'h3FFF},  // R3 jump to top
    {1'b1, 3'd0, 10'h000, 8'h00, 4'h0, 14'h0000},  // R2 wrap
    {1'b1, 3'd7, 10'h155, 8'h00, 4'h1, 14'h0001},  // R2 code 7 steps
    {1'b0, 3'd1, 10'h155, 8'h00, 4'h1, 14'h0001}   // R10 hold
  };

  task automatic check(input string req, input logic [13:0] exp);
    checks++;
    if (pc !== exp) begin
      fails++;
      $display("FAIL %s pc=%h expected=%h", req, pc, exp);
    end
  endtask

  // inputs change at a falling edge; result is sampled at the next one
  task automatic step(input logic en, input logic [2:0] o, input logic [9:0] i,
                      input logic [7:0] a, input logic [3:0] p);
    cyc_en = en; op = o; imm = i; acc = a; page = p;
    @(negedge clk);
  endtask

  task automatic do_reset();
    cyc_en = 1'b0; op = 3'd0; imm = '0; acc = '0; page = '0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();
    check("R1 reset", 14'h0000);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v][39], VEC[v][38:36], VEC[v][35:26], VEC[v][25:18], VEC[v][17:14]);
      check($sformatf("R2-table vector %0d", v), VEC[v][13:0]);
    end

    // R1: reset mid-run clears address
    step(1'b1, 3'd1, 10'h2AA, 8'h00, 4'h7);
    do_reset();
    check("R1 reset after run", 14'h0000);

    // R9: nine calls then nine returns across the circular stack
    for (int k = 0; k < 9; k++) begin
      step(1'b1, 3'd2, 10'(k * 16), 8'h00, 4'h0);
      check("R4 call target", 14'(k * 16));
    end
    for (int j = 0; j < 9; j++) begin
      int kk;
      logic [13:0] exp;
      kk  = (j == 0 || j == 8) ? 8 : 8 - j;
      exp = 14'((kk - 1) * 16 + 1);
      step(1'b1, 3'd3, 10'h000, 8'h00, 4'h0);
      check("R9 circular pop", exp);
    end

    // R10: a disabled call must not touch the stack
    do_reset();
    step(1'b1, 3'd2, 10'h020, 8'h00, 4'h1);
    check("R8 call page", 14'h0420);
    step(1'b0, 3'd2, 10'h040, 8'h00, 4'h2);
    check("R10 disabled call holds pc", 14'h0420);
    step(1'b0, 3'd3, 10'h000, 8'h00, 4'h0);
    check("R10 disabled return holds pc", 14'h0420);
    step(1'b1, 3'd3, 10'h000, 8'h00, 4'h0);
    check("R10 stack untouched", 14'h0001);

    // R6: carry out of bit 7 dropped, R5 with page 0
    step(1'b1, 3'd4, 10'h000, 8'hFF, 4'h0);
    check("R5 load acc", 14'h00FF);
    step(1'b1, 3'd5, 10'h000, 8'h02, 4'hA);
    check("R6 carry dropped", 14'h2801);

    cyc_en = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule